// File: doc/BRIEF.md
# Two-Wire Serial Mode Control Register

This block is the 8-bit mode control register of a two-wire serial interface. Software writes and reads it through a simple one-cycle register port. It holds an interface enable, a reception-inhibit flag, the two bits that together select one of four operating modes, and a 4-bit transfer-clock select field. The clock select field is only stored and passed on to the clock generator.

The protocol engine reports bus events to the block as one-cycle strobes: lost arbitration, a matched slave address together with its direction bit, an overrun, and a read of the receive data register. The block applies the mode changes these events call for by itself. A format input selects which rules apply. With the format input low, the interface runs as an addressed multi-master bus, and arbitration loss and address match are honoured. With it high, the interface runs as a clocked synchronous serial link, and overrun is honoured.

When a software write and a hardware event change the same mode bit in the same cycle, the hardware event wins. The outputs are the current mode, the pin-drive enable, a one-cycle pulse that starts the next reception, and the serial clock output enable. There is no streaming data path here, so every pin is a plain control or status signal.

Top module: `twi_mode_ctl`

## Requirements
- R1: After reset, every register bit is 0, and so are rd_data, mode, bus_drive_en, rx_next, sclk_out_en and clk_sel.
- R2: A cycle with wr_en high stores wr_data at the clock edge, unless R8 applies. The register layout is: bit 7 enable, bit 6 reception inhibit, bit 5 master select, bit 4 transmit select, bits 3:0 clock select. rd_data always shows the stored value, and clk_sel equals bits 3:0.
- R3: mode is {master select, transmit select}. 2'b00 is slave receive, 2'b01 is slave transmit, 2'b10 is master receive and 2'b11 is master transmit.
- R4: bus_drive_en equals the stored enable bit. When it is 0 the pins are left to general port use.
- R5: With fmt_sync low, enable set and master select set, an ev_arb_lost strobe clears both master select and transmit select at the next edge. The block is then in slave receive mode.
- R6: With fmt_sync low, enable set and mode 2'b00, an ev_addr_match strobe with ev_addr_rw high sets transmit select at the next edge. With ev_addr_rw low, nothing changes.
- R7: With fmt_sync high, enable set and master select set, an ev_overrun strobe clears master select and transmit select at the next edge.
- R8: If a write and an event from R5 to R7 occur in the same cycle, the event's change to the mode bits wins. The other bits take the written value. Event conditions are evaluated on the register contents before the edge.
- R9: Events are ignored while enable is 0. ev_arb_lost and ev_addr_match are ignored while fmt_sync is high, and ev_overrun is ignored while fmt_sync is low.
- R10: rx_next pulses high for one cycle, one cycle after an ev_rxdata_read strobe. This happens only if, before that edge, enable was 1, transmit select was 0 and reception inhibit was 0.
- R11: sclk_out_en is high exactly when enable is set, fmt_sync is high and master select is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| fmt_sync | input | 1 | 1: clocked synchronous serial format, 0: addressed bus format |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_addr_match | input | 1 | Own slave address matched strobe |
| ev_addr_rw | input | 1 | Direction bit received with the address (1 = master reads) |
| ev_overrun | input | 1 | Overrun strobe |
| ev_rxdata_read | input | 1 | Receive data register read strobe |
| mode | output | 2 | {master select, transmit select} |
| bus_drive_en | output | 1 | Pins driven by bus logic |
| rx_next | output | 1 | Start next reception pulse |
| sclk_out_en | output | 1 | Drive serial clock output |
| clk_sel | output | 4 | Transfer clock select to clock generator |

## Verification
The bench puts a software write and an arbitration loss in the same cycle. A design that let the write win would leave the block claiming master transmit after it had lost the bus. It sends each event under the wrong format and with the interface disabled, where a decoder missing a qualifier would drop master mode for no reason. It sends an address match with the direction bit low, where a wrongly set transmit select would make the slave drive data nobody asked for. It also blocks the receive pulse through both the inhibit bit and transmit direction, because a missing gate would start a reception the software had refused.

// File: rtl/twi_mode_pkg.sv
package twi_mode_pkg;
  localparam int unsigned CS_W   = 4;
  localparam int unsigned REG_W  = CS_W + 4;
  localparam int unsigned BIT_EN = REG_W - 1;
  localparam int unsigned BIT_RX = REG_W - 2;
  localparam int unsigned BIT_MS = REG_W - 3;
  localparam int unsigned BIT_TR = REG_W - 4;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } twi_mode_e;

  typedef struct packed {
    logic            en;
    logic            rx_dis;
    logic            mst;
    logic            trs;
    logic [CS_W-1:0] cs;
  } twi_ctl_t;
endpackage

// File: rtl/twi_hw_events.sv
module twi_hw_events
  import twi_mode_pkg::*;
(
  input  twi_ctl_t cur,
  input  logic     fmt_sync,
  input  logic     ev_arb_lost,
  input  logic     ev_addr_match,
  input  logic     ev_addr_rw,
  input  logic     ev_overrun,
  output logic     clr_mst,
  output logic     clr_trs,
  output logic     set_trs
);
  logic arb_hit, ovr_hit, adr_hit;
  twi_mode_e cur_mode;

  always_comb begin
    cur_mode = twi_mode_e'({cur.mst, cur.trs});
    arb_hit  = cur.en && !fmt_sync && ev_arb_lost && cur.mst;
    ovr_hit  = cur.en &&  fmt_sync && ev_overrun  && cur.mst;
    adr_hit  = cur.en && !fmt_sync && ev_addr_match && ev_addr_rw
               && (cur_mode == MODE_SLV_RX);
    clr_mst  = arb_hit || ovr_hit;
    clr_trs  = arb_hit || ovr_hit;
    set_trs  = adr_hit;
  end
endmodule

// File: rtl/twi_mode_reg.sv
module twi_mode_reg
  import twi_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr_mst,
  input  logic             clr_trs,
  input  logic             set_trs,
  output twi_ctl_t         q
);
  twi_ctl_t nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = twi_ctl_t'(wr_data);
    if (clr_mst) nxt.mst = 1'b0;
    if (clr_trs) nxt.trs = 1'b0;
    if (set_trs) nxt.trs = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/twi_rx_gate.sv
module twi_rx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trs,
  input  logic rx_dis,
  input  logic ev_rxdata_read,
  output logic rx_next
);
  logic permit;

  always_comb permit = en && !trs && !rx_dis && ev_rxdata_read;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_next <= 1'b0;
    else        rx_next <= permit;
  end
endmodule

// File: rtl/twi_mode_ctl.sv
module twi_mode_ctl
  import twi_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             fmt_sync,
  input  logic             ev_arb_lost,
  input  logic             ev_addr_match,
  input  logic             ev_addr_rw,
  input  logic             ev_overrun,
  input  logic             ev_rxdata_read,
  output logic [1:0]       mode,
  output logic             bus_drive_en,
  output logic             rx_next,
  output logic             sclk_out_en,
  output logic [CS_W-1:0]  clk_sel
);
  twi_ctl_t ctl;
  logic clr_mst, clr_trs, set_trs;

  twi_hw_events u_ev (
    .cur           (ctl),
    .fmt_sync      (fmt_sync),
    .ev_arb_lost   (ev_arb_lost),
    .ev_addr_match (ev_addr_match),
    .ev_addr_rw    (ev_addr_rw),
    .ev_overrun    (ev_overrun),
    .clr_mst       (clr_mst),
    .clr_trs       (clr_trs),
    .set_trs       (set_trs)
  );

  twi_mode_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_mst (clr_mst),
    .clr_trs (clr_trs),
    .set_trs (set_trs),
    .q       (ctl)
  );

  twi_rx_gate u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (ctl.en),
    .trs            (ctl.trs),
    .rx_dis         (ctl.rx_dis),
    .ev_rxdata_read (ev_rxdata_read),
    .rx_next        (rx_next)
  );

  assign rd_data      = ctl;
  assign mode         = {ctl.mst, ctl.trs};
  assign bus_drive_en = ctl.en;
  assign sclk_out_en  = ctl.en && fmt_sync && ctl.mst;
  assign clk_sel      = ctl.cs;
endmodule

// File: rtl/twi_mode_chk.sv
module twi_mode_chk
  import twi_mode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic             fmt_sync,
  input logic             ev_arb_lost,
  input logic             ev_addr_match,
  input logic             ev_addr_rw,
  input logic             ev_overrun,
  input logic             ev_rxdata_read,
  input logic [1:0]       mode,
  input logic             rx_next,
  input logic             sclk_out_en
);
  AST_ARB_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost && !fmt_sync && rd_data[BIT_EN] && mode[1]) |=> (mode == 2'b00)); // R5
  AST_ADDR_SETS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_match && ev_addr_rw && !fmt_sync && rd_data[BIT_EN] && mode == 2'b00) |=> mode[0]); // R6
  AST_OVR_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && fmt_sync && rd_data[BIT_EN] && mode[1]) |=> (mode == 2'b00)); // R7
  AST_IDLE_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BIT_EN] && !wr_en) |=> $stable(mode)); // R9
  AST_RXNEXT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_next |-> $past(ev_rxdata_read)); // R10
  AST_SCLK_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out_en |-> (mode[1] && rd_data[BIT_EN])); // R11
endmodule

bind twi_mode_ctl twi_mode_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .rd_data        (rd_data),
  .fmt_sync       (fmt_sync),
  .ev_arb_lost    (ev_arb_lost),
  .ev_addr_match  (ev_addr_match),
  .ev_addr_rw     (ev_addr_rw),
  .ev_overrun     (ev_overrun),
  .ev_rxdata_read (ev_rxdata_read),
  .mode           (mode),
  .rx_next        (rx_next),
  .sclk_out_en    (sclk_out_en)
);

// File: tb/tb_twi_mode_ctl.sv
module tb_twi_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic fmt_sync = 1'b0, ev_arb_lost = 1'b0, ev_addr_match = 1'b0;
  logic ev_addr_rw = 1'b0, ev_overrun = 1'b0, ev_rxdata_read = 1'b0;
  logic [1:0] mode;
  logic bus_drive_en, rx_next, sclk_out_en;
  logic [3:0] clk_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  twi_mode_ctl dut (.*);

  always #5 clk = ~clk;

  // behavioural reference: register image as an integer, pulse as a bit
  int  m_reg = 0;
  bit  m_rx  = 0;

  always @(posedge clk) begin
    int nv;
    bit en, rxd, ms, tr;
    if (!rst_n) begin
      m_reg = 0; m_rx = 0;
    end else begin
      en  = m_reg[7]; rxd = m_reg[6]; ms = m_reg[5]; tr = m_reg[4];
      m_rx = en && !tr && !rxd && ev_rxdata_read;
      nv = wr_en ? int'(wr_data) : m_reg;
      if (en && ms && ((!fmt_sync && ev_arb_lost) || (fmt_sync && ev_overrun)))
        nv = nv & ~32'h30;
      else if (en && !fmt_sync && !ms && !tr && ev_addr_match && ev_addr_rw)
        nv = nv | 32'h10;
      m_reg = nv;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 rd_data",      int'(rd_data), m_reg & 8'hFF);
    chk("R2 clk_sel",      int'(clk_sel), m_reg & 4'hF);
    chk("R3 mode",         int'(mode), (m_reg >> 4) & 3);
    chk("R4 bus_drive_en", int'(bus_drive_en), (m_reg >> 7) & 1);
    chk("R10 rx_next",     int'(rx_next), int'(m_rx));
    chk("R11 sclk_out_en", int'(sclk_out_en),
        int'(m_reg[7] && fmt_sync && m_reg[5]));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0; ev_arb_lost = 0; ev_addr_match = 0; ev_addr_rw = 0;
    ev_overrun = 0; ev_rxdata_read = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1; wr_data = v; cyc();
  endtask

  initial begin
    @(negedge clk); cyc(); cyc();
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset outputs", int'({mode, bus_drive_en, rx_next, sclk_out_en, clk_sel}), 0);
    rst_n = 1;
    cyc();
    chk("R1 after release", int'(rd_data), 0);

    wr(8'hA5);
    chk("R2 write readback", int'(rd_data), 8'hA5);
    chk("R2 clk_sel field", int'(clk_sel), 5);
    chk("R3 master receive", int'(mode), 2);

    wr(8'hB0);
    ev_arb_lost = 1; cyc();
    chk("R5 arb lost to slave rx", int'(mode), 0);

    ev_addr_match = 1; ev_addr_rw = 0; cyc();
    chk("R6 rw=0 no change", int'(mode), 0);
    ev_addr_match = 1; ev_addr_rw = 1; cyc();
    chk("R6 rw=1 sets transmit", int'(mode), 1);

    fmt_sync = 1;
    wr(8'hA0);
    chk("R11 clock out in sync master", int'(sclk_out_en), 1);
    ev_arb_lost = 1; cyc();
    chk("R9 arb ignored in sync fmt", int'(mode), 2);
    ev_overrun = 1; cyc();
    chk("R7 overrun to slave rx", int'(mode), 0);
    chk("R11 clock off after overrun", int'(sclk_out_en), 0);

    fmt_sync = 0;
    wr(8'hB0);
    ev_overrun = 1; cyc();
    chk("R9 overrun ignored in bus fmt", int'(mode), 3);
    ev_arb_lost = 1; wr(8'hB3);
    chk("R8 event beats write", int'(rd_data), 8'h83);

    wr(8'h30);
    ev_arb_lost = 1; cyc();
    chk("R9 disabled ignores arb", int'(mode), 3);

    wr(8'h80);
    ev_rxdata_read = 1; cyc();
    chk("R10 pulse after read", int'(rx_next), 1);
    cyc();
    chk("R10 single cycle pulse", int'(rx_next), 0);
    wr(8'hC0);
    ev_rxdata_read = 1; cyc();
    chk("R10 inhibited no pulse", int'(rx_next), 0);
    wr(8'h90);
    ev_rxdata_read = 1; cyc();
    chk("R10 transmit dir no pulse", int'(rx_next), 0);

    for (int i = 0; i < 3000; i++) begin
      wr_en          = ($urandom_range(0, 7) == 0);
      wr_data        = 8'($urandom);
      fmt_sync       = ($urandom_range(0, 15) == 0) ? ~fmt_sync : fmt_sync;
      ev_arb_lost    = ($urandom_range(0, 5) == 0);
      ev_addr_match  = ($urandom_range(0, 4) == 0);
      ev_addr_rw     = 1'($urandom);
      ev_overrun     = ($urandom_range(0, 5) == 0);
      ev_rxdata_read = ($urandom_range(0, 3) == 0);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule